// File: doc/BRIEF.md
# Counter Byte Access Sequencer

This block sits between an 8-bit data bus and one 16-bit counter channel. On the write side it builds an initial count from bus bytes and hands it on with a one-cycle load strobe. On the read side it turns the 16-bit count into a byte stream. Both sides follow the access mode chosen when the channel is programmed: low byte only, high byte only, or low byte followed by high byte. Mode decoding and the counting itself are done by neighbouring logic, which supplies the live count and takes the assembled load value.

A latch command takes a snapshot of the live count. Reads return the snapshot until the full byte sequence of the current access mode has been read. After that, reads follow the live count again. Programming the channel sets both byte toggles back to "low byte next", drops a half-written count and drops any held snapshot. The read toggle and the write toggle are separate, so reads and writes can be interleaved without disturbing each other. Bytes pass through unchanged, so packed BCD digits stay as they are.

`rd_data` is combinational. It shows the byte that a read strobed in the current cycle returns.

Top module: `cnt_byte_seq`

## Requirements
- R1: In access mode 1 (`acc_mode` code 1, low byte only), each write loads `{8'h00, wr_data}`.
- R2: In access mode 2 (code 2, high byte only), each write loads `{wr_data, 8'h00}`.
- R3: In access mode 3 (code 3, low then high), the first write only stores the low byte and gives no load strobe. The second write loads `{second byte, first byte}`.
- R4: `load_pulse` is high for exactly the one cycle after the clock edge that takes the final byte of a write sequence. `load_value` is valid in that cycle.
- R5: Without a latch held, `rd_data` is taken from the live count: bits 7:0 in mode 1, bits 15:8 in mode 2, and in mode 3 alternately the low byte then the high byte, moving on with each `rd_en`.
- R6: A latch command captures the live count. Reads return bytes of that snapshot until the last byte of the mode's sequence has been read (one read in modes 1 and 2, the high-byte read in mode 3). Reads then track the live count again.
- R7: A latch command given while a snapshot is still held is ignored, and the first snapshot is kept.
- R8: A program event with a nonzero code sets the read toggle and the write toggle to the low byte, drops a stored low byte and drops a held snapshot.
- R9: A program event with code 0 is ignored. The access mode, toggles and snapshot are unchanged.
- R10: The read toggle and the write toggle are independent. A write between two reads does not shift the read byte position, and a read between two writes does not shift the write byte position.
- R11: Bytes are moved without any conversion, so packed BCD digits reach `load_value` and `rd_data` unchanged.
- R12: A program event wins over a write, read or latch command in the same cycle, and those commands have no effect.
- R13: After reset the access mode is 3, both toggles point to the low byte, no snapshot is held, `load_pulse` is 0 and `load_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog | input | 1 | Program event; applies `acc_mode` |
| acc_mode | input | 2 | Access mode code: 1 low, 2 high, 3 low then high, 0 ignored |
| wr_en | input | 1 | Write strobe for one data byte |
| wr_data | input | 8 | Data byte written |
| rd_en | input | 1 | Read strobe; advances the read sequence |
| latch_cmd | input | 1 | Count latch command |
| live_count | input | 16 | Current count from the counter |
| load_value | output | 16 | Assembled initial count |
| load_pulse | output | 1 | One-cycle strobe when `load_value` is new |
| rd_data | output | 8 | Byte returned by a read in this cycle |

## Verification
Writes are swept over a spread of byte values in each access mode. Zero padding on the unused half tells mode 1 from mode 2, and distinct first and second bytes show that mode 3 keeps the right byte order. Reads use a live count that changes between reads, so a value from the snapshot can be told apart from a live value, and it shows exactly at which read the snapshot is released. Interleaved read and write sequences, reprogramming in the middle of a sequence, and reprogramming in the same cycle as a command show that the two toggles are independent and that the program event has priority.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LH   = 2'd3
    } acc_e;

    // true when a read in this mode/toggle state ends the byte sequence
    function automatic logic seq_last(input acc_e acc, input logic tog);
        return (acc != ACC_LH) || tog;
    endfunction

endpackage

// File: rtl/cbs_mode_reg.sv
module cbs_mode_reg
    import cbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog,
    input  logic [1:0] acc_mode,
    output logic       prog_ok,
    output acc_e       acc
);

    typedef struct packed {
        acc_e mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        prog_ok = prog && (acc_e'(acc_mode) != ACC_NONE);
        st_d    = st_q;
        if (prog_ok) begin
            st_d.mode = acc_e'(acc_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= ACC_LH;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.mode;

endmodule

// File: rtl/cbs_wr_asm.sv
module cbs_wr_asm
    import cbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_ok,
    input  acc_e              acc,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  load_value,
    output logic              load_pulse,
    output logic              wr_tog
);

    localparam logic [BYTE_W-1:0] ZB = '0;

    typedef struct packed {
        logic              tog;
        logic [BYTE_W-1:0] lo;
        logic [CNT_W-1:0]  val;
        logic              pulse;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (prog_ok) begin
            st_d.tog = 1'b0;
            st_d.lo  = ZB;
        end else if (wr_en) begin
            unique case (acc)
                ACC_LO: begin
                    st_d.val   = {ZB, wr_data};
                    st_d.pulse = 1'b1;
                end
                ACC_HI: begin
                    st_d.val   = {wr_data, ZB};
                    st_d.pulse = 1'b1;
                end
                ACC_LH: begin
                    if (!st_q.tog) begin
                        st_d.lo  = wr_data;
                        st_d.tog = 1'b1;
                    end else begin
                        st_d.val   = {wr_data, st_q.lo};
                        st_d.pulse = 1'b1;
                        st_d.tog   = 1'b0;
                    end
                end
                default: begin
                    st_d = st_d;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_value = st_q.val;
    assign load_pulse = st_q.pulse;
    assign wr_tog     = st_q.tog;

endmodule

// File: rtl/cbs_rd_ser.sv
module cbs_rd_ser
    import cbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_ok,
    input  acc_e              acc,
    input  logic              rd_en,
    input  logic              latch_cmd,
    input  logic [CNT_W-1:0]  live_count,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_tog,
    output logic              rd_held,
    output logic [CNT_W-1:0]  rd_snap
);

    typedef struct packed {
        logic             tog;
        logic             held;
        logic [CNT_W-1:0] snap;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [CNT_W-1:0] view;
    logic             pick_hi;

    always_comb begin
        st_d = st_q;
        if (prog_ok) begin
            st_d.tog  = 1'b0;
            st_d.held = 1'b0;
        end else begin
            if (rd_en) begin
                if (acc == ACC_LH) begin
                    st_d.tog = ~st_q.tog;
                end
                if (seq_last(acc, st_q.tog)) begin
                    st_d.held = 1'b0;
                end
            end
            if (latch_cmd && !st_q.held) begin
                st_d.held = 1'b1;
                st_d.snap = live_count;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        view    = st_q.held ? st_q.snap : live_count;
        pick_hi = (acc == ACC_HI) || ((acc == ACC_LH) && st_q.tog);
        rd_data = pick_hi ? view[CNT_W-1:BYTE_W] : view[BYTE_W-1:0];
    end

    assign rd_tog  = st_q.tog;
    assign rd_held = st_q.held;
    assign rd_snap = st_q.snap;

endmodule

// File: rtl/cnt_byte_seq.sv
module cnt_byte_seq
    import cbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic [1:0]        acc_mode,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              latch_cmd,
    input  logic [CNT_W-1:0]  live_count,
    output logic [CNT_W-1:0]  load_value,
    output logic              load_pulse,
    output logic [BYTE_W-1:0] rd_data
);

    acc_e             acc_q;
    logic             prog_ok;
    logic             wr_tog;
    logic             rd_tog;
    logic             rd_held;
    logic [CNT_W-1:0] rd_snap;

    cbs_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog     (prog),
        .acc_mode (acc_mode),
        .prog_ok  (prog_ok),
        .acc      (acc_q)
    );

    cbs_wr_asm #(.BYTE_W(BYTE_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_ok    (prog_ok),
        .acc        (acc_q),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .load_value (load_value),
        .load_pulse (load_pulse),
        .wr_tog     (wr_tog)
    );

    cbs_rd_ser #(.BYTE_W(BYTE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_ok    (prog_ok),
        .acc        (acc_q),
        .rd_en      (rd_en),
        .latch_cmd  (latch_cmd),
        .live_count (live_count),
        .rd_data    (rd_data),
        .rd_tog     (rd_tog),
        .rd_held    (rd_held),
        .rd_snap    (rd_snap)
    );

endmodule

// File: rtl/cnt_byte_seq_chk.sv
module cnt_byte_seq_chk
    import cbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog,
    input logic [1:0]       acc_mode,
    input logic             wr_en,
    input logic             rd_en,
    input logic             latch_cmd,
    input logic [CNT_W-1:0] load_value,
    input logic             load_pulse,
    input acc_e             acc_q,
    input logic             wr_tog,
    input logic             rd_tog,
    input logic             rd_held,
    input logic [CNT_W-1:0] rd_snap
);

    logic prog_valid;
    assign prog_valid = prog && (acc_mode != 2'd0);

    assert_lo_mode_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && acc_q == ACC_LO) |-> (load_value[CNT_W-1:BYTE_W] == '0));

    assert_hi_mode_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && acc_q == ACC_HI) |-> (load_value[BYTE_W-1:0] == '0));

    assert_pair_second_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && acc_q == ACC_LH) |-> ($past(wr_tog) && !wr_tog));

    assert_pulse_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> ($past(wr_en) && !$past(prog_valid)));

    assert_snapshot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_held && $past(rd_held)) |-> $stable(rd_snap));

    assert_relatch_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_cmd && rd_held && !rd_en && !prog) |=> (rd_held && $stable(rd_snap)));

    assert_prog_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |=> (!wr_tog && !rd_tog && !rd_held));

    assert_code0_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && acc_mode == 2'd0) |=> $stable(acc_q));

    assert_prog_blocks_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |=> !load_pulse);

endmodule

bind cnt_byte_seq cnt_byte_seq_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog       (prog),
    .acc_mode   (acc_mode),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .latch_cmd  (latch_cmd),
    .load_value (load_value),
    .load_pulse (load_pulse),
    .acc_q      (acc_q),
    .wr_tog     (wr_tog),
    .rd_tog     (rd_tog),
    .rd_held    (rd_held),
    .rd_snap    (rd_snap)
);

// File: tb/test_cnt_byte_seq.sv
module test_cnt_byte_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog;
    logic [1:0]  acc_mode;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic        latch_cmd;
    logic [15:0] live_count;
    logic [15:0] load_value;
    logic        load_pulse;
    logic [7:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cnt_byte_seq i_cnt_byte_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog       (prog),
        .acc_mode   (acc_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .latch_cmd  (latch_cmd),
        .live_count (live_count),
        .load_value (load_value),
        .load_pulse (load_pulse),
        .rd_data    (rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_prog(input logic [1:0] m);
        prog = 1'b1; acc_mode = m;
        @(negedge clk);
        prog = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] r);
        #1;
        r = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_latch();
        latch_cmd = 1'b1;
        @(negedge clk);
        latch_cmd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] a;
        logic [15:0] b;
        rst_n = 1'b0; prog = 1'b0; acc_mode = 2'd0; wr_en = 1'b0; wr_data = 8'h00;
        rd_en = 1'b0; latch_cmd = 1'b0; live_count = 16'hA55A;
        repeat (3) @(negedge clk);
        #1;
        // R13: reset state, mode 3 with low byte first
        chk("R13 pulse", {15'd0, load_pulse}, 16'd0);
        chk("R13 value", load_value, 16'h0000);
        chk("R13 rd low first", {8'h00, rd_data}, 16'h005A);
        rst_n = 1'b1;
        idle();
        do_read(r);
        chk("R13 read low", {8'h00, r}, 16'h005A);
        do_read(r);
        chk("R13 read high", {8'h00, r}, 16'h00A5);

        // R1 sweep: low byte only
        do_prog(2'd1);
        for (int v = 0; v < 256; v += 17) begin
            do_write(8'(v));
            chk("R1 pulse", {15'd0, load_pulse}, 16'd1);
            chk("R1 value", load_value, {8'h00, 8'(v)});
        end
        idle();
        chk("R4 pulse drops", {15'd0, load_pulse}, 16'd0);

        // R2 sweep: high byte only
        do_prog(2'd2);
        for (int v = 0; v < 256; v += 17) begin
            do_write(8'(v));
            chk("R2 pulse", {15'd0, load_pulse}, 16'd1);
            chk("R2 value", load_value, {8'(v), 8'h00});
        end
        idle();
        chk("R4 pulse drops", {15'd0, load_pulse}, 16'd0);

        // R3 sweep: low then high
        do_prog(2'd3);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] lo;
            logic [7:0] hi;
            lo = 8'((i * 29) & 255);
            hi = 8'((i * 53 + 7) & 255);
            do_write(lo);
            chk("R3 no pulse on first byte", {15'd0, load_pulse}, 16'd0);
            do_write(hi);
            chk("R3 pulse on second byte", {15'd0, load_pulse}, 16'd1);
            chk("R3 value", load_value, {hi, lo});
            idle();
            chk("R4 single cycle", {15'd0, load_pulse}, 16'd0);
        end

        // R5: unlatched reads track the live count in every mode
        for (int m = 1; m < 4; m++) begin
            do_prog(2'(m));
            for (int k = 0; k < 8; k++) begin
                a = 16'((k * 4099 + 321 * m) & 16'hFFFF);
                b = 16'((k * 7919 + 1000) & 16'hFFFF);
                live_count = a;
                do_read(r);
                chk("R5 first read", {8'h00, r}, {8'h00, (m == 2) ? a[15:8] : a[7:0]});
                live_count = b;
                do_read(r);
                chk("R5 second read", {8'h00, r}, {8'h00, (m == 1) ? b[7:0] : b[15:8]});
            end
        end

        // R6: snapshot held until sequence ends, for each mode
        for (int m = 1; m < 4; m++) begin
            do_prog(2'(m));
            for (int k = 0; k < 6; k++) begin
                a = 16'((k * 9001 + 77 * m) & 16'hFFFF);
                b = ~a;
                live_count = a;
                do_latch();
                live_count = b;
                idle();
                do_read(r);
                chk("R6 frozen first", {8'h00, r}, {8'h00, (m == 2) ? a[15:8] : a[7:0]});
                if (m == 3) begin
                    do_read(r);
                    chk("R6 frozen high", {8'h00, r}, {8'h00, a[15:8]});
                end
                do_read(r);
                chk("R6 live after release", {8'h00, r}, {8'h00, (m == 2) ? b[15:8] : b[7:0]});
                if (m == 3) begin
                    do_read(r);
                    chk("R6 live high", {8'h00, r}, {8'h00, b[15:8]});
                end
            end
        end

        // R7: second latch while held is ignored
        do_prog(2'd3);
        live_count = 16'h1357;
        do_latch();
        live_count = 16'h2468;
        do_latch();
        live_count = 16'h9BDF;
        do_read(r);
        chk("R7 first snapshot low", {8'h00, r}, 16'h0057);
        do_read(r);
        chk("R7 first snapshot high", {8'h00, r}, 16'h0013);
        do_latch();
        live_count = 16'h0F0F;
        do_read(r);
        chk("R7 new latch after release", {8'h00, r}, 16'h00DF);
        do_read(r);
        chk("R7 new latch high", {8'h00, r}, 16'h009B);

        // R8: program resets pending byte, read toggle and snapshot
        do_prog(2'd3);
        do_write(8'hAA);
        do_prog(2'd3);
        do_write(8'h11);
        chk("R8 pending dropped", {15'd0, load_pulse}, 16'd0);
        do_write(8'h22);
        chk("R8 fresh pair", load_value, 16'h2211);
        live_count = 16'h4321;
        do_read(r);
        do_prog(2'd3);
        do_read(r);
        chk("R8 read toggle reset", {8'h00, r}, 16'h0021);
        do_read(r);
        live_count = 16'h5555;
        do_latch();
        live_count = 16'h6789;
        do_prog(2'd3);
        do_read(r);
        chk("R8 snapshot dropped", {8'h00, r}, 16'h0089);
        do_read(r);

        // R9: code 0 ignored
        do_prog(2'd1);
        do_prog(2'd0);
        do_write(8'h3C);
        chk("R9 mode kept", load_value, 16'h003C);
        do_prog(2'd3);
        do_write(8'h44);
        do_prog(2'd0);
        do_write(8'h55);
        chk("R9 toggle kept pulse", {15'd0, load_pulse}, 16'd1);
        chk("R9 toggle kept value", load_value, 16'h5544);

        // R10: independent toggles
        do_prog(2'd3);
        live_count = 16'hBEEF;
        do_write(8'h01);
        do_read(r);
        chk("R10 read low after write", {8'h00, r}, 16'h00EF);
        do_write(8'h02);
        chk("R10 write pair intact", load_value, 16'h0201);
        do_read(r);
        chk("R10 read high after write", {8'h00, r}, 16'h00BE);

        // R11: packed BCD bytes unchanged
        do_write(8'h59);
        do_write(8'h99);
        chk("R11 bcd load", load_value, 16'h9959);
        live_count = 16'h0987;
        do_latch();
        live_count = 16'h0000;
        do_read(r);
        chk("R11 bcd read low", {8'h00, r}, 16'h0087);
        do_read(r);
        chk("R11 bcd read high", {8'h00, r}, 16'h0009);

        // R12: program wins over same-cycle write and latch
        do_write(8'h77);
        prog = 1'b1; acc_mode = 2'd3; wr_en = 1'b1; wr_data = 8'hEE;
        latch_cmd = 1'b1; live_count = 16'h1111;
        @(negedge clk);
        prog = 1'b0; wr_en = 1'b0; latch_cmd = 1'b0;
        chk("R12 write ignored", {15'd0, load_pulse}, 16'd0);
        live_count = 16'h2222;
        do_read(r);
        chk("R12 latch ignored", {8'h00, r}, 16'h0022);
        do_read(r);
        do_write(8'h0A);
        do_write(8'h0B);
        chk("R12 clean pair", load_value, 16'h0B0A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule